// File: doc/BRIEF.md
# Event-Code Triggered Delay and Pulse Generator Bank

This block sits on the receive side of a timing event link. Each reference clock cycle it takes one 8-bit event code from the already decoded frame stream (the frame's data byte is not brought into this block). The code indexes a mapping RAM whose entry is a bit mask over the trigger outputs. Each output named in the mask starts its own delay counter and, once the delay has run out, drives a pulse of programmable width at a programmable polarity.

A host writes the mapping RAM through a simple write port and configures the outputs through a small write-only register space. A global enable bit gates the whole bank. Outputs that receive a code while they are still busy ignore it and raise a sticky flag that the host can clear.

Top module: `evt_pulse_gen`

## Requirements
- R1: After synchronous reset all trigger outputs are low, all missed flags are 0, the bank is disabled, every mapping entry is 0 and every delay, width and polarity register is 0.
- R2: A write with `map_we` high stores `map_data` in mapping entry `map_addr`; bit i of an entry selects trigger output i. A code whose entry is 0 fires nothing, and a rewritten entry takes effect for later codes.
- R3: With the bank enabled, a code presented at clock edge E0 whose entry selects output i, with delay D (0 to 2^28-1) and width W > 0, makes output i active from edge E0+1+D through edge E0+D+W, that is for exactly W cycles.
- R4: An output whose width register is 0 neither pulses nor changes its missed flag when its code arrives.
- R5: Each output equals its polarity bit XOR its active state: polarity 0 gives an active-high pulse on a low idle level, polarity 1 an active-low pulse on a high idle level.
- R6: A selecting code that arrives while an output is in its delay or pulse phase leaves that output's timing unchanged and sets its missed flag; the flag stays set until a write to the control register with bit 1 set.
- R7: Control bit 0 is the global enable. One edge after it is cleared every output sits at its polarity level, a running delay or pulse is cut off, incoming codes are ignored and missed flags do not get set.
- R8: Register address = 4*(n+1)+f for output n, field f: f=0 delay in data bits 27:0, f=1 width in bits 15:0, f=2 polarity in bit 0. Address 0 is control: bit 0 enable, bit 1 write-one-to-clear all missed flags.
- R9: Delay and width are captured when an output starts; writing its delay or width register during a running delay does not move the pulse already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one event code per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_code | input | 8 | Event code byte of the current frame |
| map_we | input | 1 | Mapping RAM write strobe |
| map_addr | input | 8 | Mapping entry (event code) to write |
| map_data | input | 14 | Output selection mask to store |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_data | input | 28 | Register write data |
| trig_out | output | 14 | Trigger outputs, one per channel |
| missed_out | output | 14 | Sticky per-output missed-code flags |

## Verification
A code captured at edge E0 is looked up at that edge and loads the channel counters at E0+1, so an output becomes active after edge E0+1+D and returns to idle after edge E0+1+D+W; the bench samples on the falling edge following each rising edge and compares every output against that window computed from the configured D and W. A second code sent k cycles after the first sets the missed flag two edges after it is presented, and a register write takes effect at the edge that samples it, with enable-off cutting outputs one edge later; the bench places its expected-value windows on those counts. Every channel is swept with its own delay and width, and polarity, zero width, retrigger, cut-off, remapping and a long delay are each run as separate windows.

// File: rtl/evt_pkg.sv
// Shared types for the event-code pulse generator bank.
// Assumes nothing beyond the standard: only types and constants live here.
package evt_pkg;

    // Channel phase: waiting for a code, counting delay, driving the pulse.
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_FIRE = 2'd2
    } chan_state_e;

    // Register field selectors within a channel's four-word slot.
    localparam logic [1:0] FLD_DELAY = 2'd0;
    localparam logic [1:0] FLD_WIDTH = 2'd1;
    localparam logic [1:0] FLD_POL   = 2'd2;

endpackage

// File: rtl/evt_map_ram.sv
// Event-code mapping RAM: one output-selection mask per event code.
// Read is synchronous (mask valid the cycle after the code); a write to the
// same entry in the same cycle returns the old mask. Reset clears all entries.
module evt_map_ram #(
    parameter int CODE_W  = 8,
    parameter int NUM_OUT = 14,
    localparam int DEPTH  = 1 << CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CODE_W-1:0]  wr_addr,
    input  logic [NUM_OUT-1:0] wr_data,
    input  logic [CODE_W-1:0]  rd_addr,
    output logic [NUM_OUT-1:0] rd_data
);

    logic [NUM_OUT-1:0] mem [DEPTH];

    // Clear on reset, otherwise write the host entry and look up the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem[e] <= '0;
            end
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
            end
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/evt_cfg_regs.sv
// Host configuration registers: global control plus delay, width and
// polarity for each output. Write-only; address = 4*(channel+1)+field,
// address 0 is control. Assumes DATA_W covers the widest field.
module evt_cfg_regs
    import evt_pkg::*;
#(
    parameter int NUM_OUT = 14,
    parameter int DLY_W   = 28,
    parameter int WID_W   = 16,
    localparam int REG_AW = $clog2(4 * (NUM_OUT + 1)),
    localparam int CH_AW  = REG_AW - 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [REG_AW-1:0]             addr,
    input  logic [DLY_W-1:0]              wdata,
    output logic                          en,
    output logic                          miss_clr,
    output logic [NUM_OUT-1:0][DLY_W-1:0] dly_vec,
    output logic [NUM_OUT-1:0][WID_W-1:0] wid_vec,
    output logic [NUM_OUT-1:0]            pol_vec
);

    logic [CH_AW-1:0] slot;
    logic [1:0]       fld;

    // Split the address into channel slot and field.
    always_comb begin
        slot = addr[REG_AW-1:2];
        fld  = addr[1:0];
    end

    // Clear-missed strobe lasts the single cycle of the control write.
    always_comb begin
        miss_clr = we && (addr == '0) && wdata[1];
    end

    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (we && (addr == '0)) begin
            en <= wdata[0];
        end
    end

    // Per-channel field registers.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly_vec[i] <= '0;
                wid_vec[i] <= '0;
                pol_vec[i] <= 1'b0;
            end else if (we && (slot == CH_AW'(i + 1))) begin
                case (fld)
                    FLD_DELAY: dly_vec[i] <= wdata;
                    FLD_WIDTH: wid_vec[i] <= wdata[WID_W-1:0];
                    FLD_POL:   pol_vec[i] <= wdata[0];
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/evt_pulse_chan.sv
// One trigger channel: on a hit it captures delay and width, counts the
// delay down, then drives an active pulse for width cycles. Hits while busy
// are dropped and latch the sticky missed flag. Disabled means idle.
// Assumes hit is a registered one-cycle-per-code strobe.
module evt_pulse_chan
    import evt_pkg::*;
#(
    parameter int DLY_W = 28,
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic [DLY_W-1:0] dly,
    input  logic [WID_W-1:0] wid,
    input  logic             pol,
    input  logic             miss_clr,
    output logic             trig,
    output logic             busy,
    output logic             fire,
    output logic             missed
);

    chan_state_e      state;
    logic [DLY_W-1:0] dly_cnt;
    logic [WID_W-1:0] wid_cnt;

    // Phase flags seen by the output stage and the checker.
    always_comb begin
        busy = (state != CH_IDLE);
        fire = (state == CH_FIRE);
        trig = pol ^ fire;
    end

    // Delay/width counter pair and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state   <= CH_IDLE;
            dly_cnt <= '0;
            wid_cnt <= '0;
        end else begin
            case (state)
                CH_IDLE: begin
                    if (hit && (wid != '0)) begin
                        wid_cnt <= wid;
                        dly_cnt <= dly;
                        state   <= (dly == '0) ? CH_FIRE : CH_WAIT;
                    end
                end
                CH_WAIT: begin
                    if (dly_cnt == DLY_W'(1)) begin
                        state <= CH_FIRE;
                    end
                    dly_cnt <= dly_cnt - DLY_W'(1);
                end
                CH_FIRE: begin
                    if (wid_cnt == WID_W'(1)) begin
                        state <= CH_IDLE;
                    end
                    wid_cnt <= wid_cnt - WID_W'(1);
                end
                default: state <= CH_IDLE;
            endcase
        end
    end

    // Sticky missed flag: set by a hit while busy, cleared by host strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            missed <= 1'b0;
        end else if (en && hit && busy) begin
            missed <= 1'b1;
        end else if (miss_clr) begin
            missed <= 1'b0;
        end
    end

endmodule

// File: rtl/evt_pulse_gen.sv
// Top of the event-code pulse generator bank. Looks each event code up in
// the mapping RAM and hands the resulting mask to one channel per output.
// Assumes codes arrive one per clock, already decoded from the frame.
module evt_pulse_gen #(
    parameter int CODE_W  = 8,
    parameter int NUM_OUT = 14,
    parameter int DLY_W   = 28,
    parameter int WID_W   = 16,
    localparam int REG_AW = $clog2(4 * (NUM_OUT + 1))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  evt_code,
    input  logic               map_we,
    input  logic [CODE_W-1:0]  map_addr,
    input  logic [NUM_OUT-1:0] map_data,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DLY_W-1:0]   reg_data,
    output logic [NUM_OUT-1:0] trig_out,
    output logic [NUM_OUT-1:0] missed_out
);

    logic                          cfg_en;
    logic                          miss_clr;
    logic [NUM_OUT-1:0][DLY_W-1:0] dly_vec;
    logic [NUM_OUT-1:0][WID_W-1:0] wid_vec;
    logic [NUM_OUT-1:0]            pol_vec;
    logic [NUM_OUT-1:0]            hit_vec;
    logic [NUM_OUT-1:0]            busy_vec;
    logic [NUM_OUT-1:0]            fire_vec;

    evt_map_ram #(
        .CODE_W  (CODE_W),
        .NUM_OUT (NUM_OUT)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we),
        .wr_addr (map_addr),
        .wr_data (map_data),
        .rd_addr (evt_code),
        .rd_data (hit_vec)
    );

    evt_cfg_regs #(
        .NUM_OUT (NUM_OUT),
        .DLY_W   (DLY_W),
        .WID_W   (WID_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_data),
        .en       (cfg_en),
        .miss_clr (miss_clr),
        .dly_vec  (dly_vec),
        .wid_vec  (wid_vec),
        .pol_vec  (pol_vec)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
        evt_pulse_chan #(
            .DLY_W (DLY_W),
            .WID_W (WID_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (cfg_en),
            .hit      (hit_vec[i]),
            .dly      (dly_vec[i]),
            .wid      (wid_vec[i]),
            .pol      (pol_vec[i]),
            .miss_clr (miss_clr),
            .trig     (trig_out[i]),
            .busy     (busy_vec[i]),
            .fire     (fire_vec[i]),
            .missed   (missed_out[i])
        );
    end

endmodule

// File: rtl/evt_pulse_chk.sv
// Property checker for evt_pulse_gen, attached by bind. Observes the
// channel phase vectors, configuration and outputs; drives nothing.
module evt_pulse_chk #(
    parameter int NUM_OUT = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_en,
    input logic               miss_clr,
    input logic [NUM_OUT-1:0] hit_vec,
    input logic [NUM_OUT-1:0] busy_vec,
    input logic [NUM_OUT-1:0] fire_vec,
    input logic [NUM_OUT-1:0] pol_vec,
    input logic [NUM_OUT-1:0] trig_out,
    input logic [NUM_OUT-1:0] missed_out
);

    // R7: one edge after the bank is disabled every output rests at its polarity.
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (trig_out == pol_vec));

    // R7: no channel is in its pulse phase one edge after disable.
    assert_no_fire_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (fire_vec == '0));

    // R7: with the bank disabled and no clear, missed flags hold.
    assert_missed_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !miss_clr) |=> $stable(missed_out));

    // R6: without a clear strobe no missed flag ever falls.
    assert_missed_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_clr |=> ((~missed_out & $past(missed_out)) == '0));

    // R3: a channel leaves idle only on a looked-up hit.
    assert_start_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> ((busy_vec & ~$past(busy_vec) & ~$past(hit_vec)) == '0));

endmodule

bind evt_pulse_gen evt_pulse_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .miss_clr   (miss_clr),
    .hit_vec    (hit_vec),
    .busy_vec   (busy_vec),
    .fire_vec   (fire_vec),
    .pol_vec    (pol_vec),
    .trig_out   (trig_out),
    .missed_out (missed_out)
);

// File: tb/sim_evt_pulse_gen.sv
// Bench for evt_pulse_gen: per-channel delay/width sweep plus polarity,
// zero width, retrigger, disable cut-off, remap and long-delay windows.
module sim_evt_pulse_gen;

    localparam int NO = 14;
    localparam int AW = 6;
    localparam int DW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    evt_code = '0;
    logic          map_we = 1'b0;
    logic [7:0]    map_addr = '0;
    logic [NO-1:0] map_data = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_data = '0;
    logic [NO-1:0] trig_out;
    logic [NO-1:0] missed_out;

    int n_chk = 0;
    int n_bad = 0;
    int dly_m [NO];
    int wid_m [NO];
    logic [NO-1:0] pol_m = '0;

    always #2.5 clk = ~clk;

    evt_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .evt_code(evt_code),
        .map_we(map_we), .map_addr(map_addr), .map_data(map_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_data(reg_data),
        .trig_out(trig_out), .missed_out(missed_out)
    );

    task automatic check(input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] ra(input int ch, input int f);
        return AW'((ch + 1) * 4 + f);
    endfunction

    task automatic wr_reg(input logic [AW-1:0] a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_data = DW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_map(input int code, input logic [NO-1:0] m);
        @(negedge clk);
        map_we = 1'b1; map_addr = 8'(code); map_data = m;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic set_ch(input int ch, input int d, input int w, input logic p);
        wr_reg(ra(ch, 0), d); dly_m[ch] = d;
        wr_reg(ra(ch, 1), w); wid_m[ch] = w;
        wr_reg(ra(ch, 2), int'(p)); pol_m[ch] = p;
    endtask

    // Expected outputs k edges after the capturing edge E0.
    function automatic logic [NO-1:0] expect_at(input logic [NO-1:0] m, input int k, input int cut);
        logic [NO-1:0] r;
        for (int i = 0; i < NO; i++) begin
            r[i] = pol_m[i] ^ (m[i] && wid_m[i] > 0 && k >= 1 + dly_m[i]
                               && k <= dly_m[i] + wid_m[i] && k < cut);
        end
        return r;
    endfunction

    // Present code before edge E0, sample after each edge E0+k.
    // kind 1: register write at edge E0+ak+1; kind 2: second code at that edge.
    task automatic window(input string tag, input int code, input logic [NO-1:0] m,
                          input int n, input int kind, input int ak,
                          input logic [AW-1:0] wa, input int wd, input int cut);
        @(negedge clk);
        evt_code = 8'(code);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) evt_code = 8'h00;
            if (k == ak + 1) begin
                reg_we = 1'b0;
                evt_code = 8'h00;
            end
            if (k == ak && kind == 1) begin
                reg_we = 1'b1; reg_addr = wa; reg_data = DW'(wd);
            end
            if (k == ak && kind == 2) evt_code = 8'(code);
            check(tag, trig_out, expect_at(m, k, cut));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NO; i++) begin dly_m[i] = 0; wid_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset trig", trig_out, '0);
        check("R1 reset missed", missed_out, '0);

        // R1: all mapping entries start at 0, so no code fires even once enabled.
        wr_reg('0, 1);
        window("R1 unmapped after reset", 8'hA5, '0, 6, 0, -5, '0, 0, 1000);

        // R8 register layout, R2 mapping: channel i gets D=2i, W=i+1, code 0x20+i.
        for (int i = 0; i < NO; i++) begin
            set_ch(i, 2 * i, i + 1, 1'b0);
            wr_map(8'h20 + i, NO'(1) << i);
        end
        wr_map(8'hA5, '1);
        wr_map(8'h5A, NO'(14'h1555));

        // R3 sweep: each channel alone.
        for (int i = 0; i < NO; i++) begin
            window("R3 single channel", 8'h20 + i, NO'(1) << i, 2 * i + i + 5, 0, -5, '0, 0, 1000);
        end
        // R2/R3: one code selecting all outputs, another selecting the even ones.
        window("R2 all-channel code", 8'hA5, '1, 45, 0, -5, '0, 0, 1000);
        window("R2 even-channel code", 8'h5A, NO'(14'h1555), 45, 0, -5, '0, 0, 1000);
        window("R2 unmapped code", 8'h77, '0, 8, 0, -5, '0, 0, 1000);

        // R5: odd channels inverted.
        for (int i = 1; i < NO; i += 2) begin
            wr_reg(ra(i, 2), 1); pol_m[i] = 1'b1;
        end
        @(negedge clk);
        check("R5 idle level", trig_out, NO'(14'h2AAA));
        window("R5 inverted all", 8'hA5, '1, 45, 0, -5, '0, 0, 1000);
        for (int i = 1; i < NO; i += 2) begin
            wr_reg(ra(i, 2), 0); pol_m[i] = 1'b0;
        end

        // R4: zero width, then a retrigger on it must not set missed.
        wr_reg(ra(0, 1), 0); wid_m[0] = 0;
        window("R4 zero width", 8'h20, NO'(1), 8, 2, 1, '0, 0, 1000);
        check("R4 missed untouched", missed_out, '0);
        wr_reg(ra(0, 1), 1); wid_m[0] = 1;

        // R6: ch5 D=10 W=6, second code during delay.
        set_ch(5, 10, 6, 1'b0);
        window("R6 retrigger ignored", 8'h25, NO'(1) << 5, 20, 2, 3, '0, 0, 1000);
        check("R6 missed set", missed_out, NO'(1) << 5);
        repeat (4) @(negedge clk);
        check("R6 missed sticky", missed_out, NO'(1) << 5);
        wr_reg('0, 3);
        check("R6 missed cleared", missed_out, '0);

        // R9: delay rewritten mid-delay does not move the pulse.
        set_ch(4, 8, 4, 1'b0);
        window("R9 captured delay", 8'h24, NO'(1) << 4, 16, 1, 2, ra(4, 0), 20, 1000);
        dly_m[4] = 20;
        window("R9 new delay used", 8'h24, NO'(1) << 4, 28, 0, -5, '0, 0, 1000);

        // R7: ch3 D=6 W=4 active at k=7..10; disable written at edge E0+8.
        window("R7 pulse cut", 8'h23, NO'(1) << 3, 14, 1, 7, '0, 0, 9);
        check("R7 no missed", missed_out, '0);
        window("R7 codes ignored", 8'h23, NO'(1) << 3, 12, 2, 2, '0, 0, 0);
        check("R7 missed not set", missed_out, '0);
        wr_reg(ra(3, 2), 1); pol_m[3] = 1'b1;
        @(negedge clk);
        check("R7 polarity level when off", trig_out, NO'(1) << 3);
        wr_reg(ra(3, 2), 0); pol_m[3] = 1'b0;
        wr_reg('0, 1);

        // R2: remap code 0x20 to channel 3.
        wr_map(8'h20, NO'(1) << 3);
        window("R2 remapped", 8'h20, NO'(1) << 3, 14, 0, -5, '0, 0, 1000);

        // R3: long delay.
        set_ch(2, 300, 3, 1'b0);
        window("R3 long delay", 8'h22, NO'(1) << 2, 306, 0, -5, '0, 0, 1000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule